// File: doc/BRIEF.md
# Outstanding TLB-Invalidate Completion Tracker

This per-hart block lets an address-translation fence retire before the invalidation it sent out has been acknowledged. The fence encoder pulses an issue strobe for every broadcast invalidate. The interconnect pulses a completion strobe, tagged with the source hart, for every acknowledgement. An internal counter holds the number of invalidates still in flight. Software sees that number only as a read-only busy flag in the supervisor status register.

Software that wants to sleep instead of polling writes 1 to a check control bit in the same status register. This arms a small state machine with three states. `TRK_IDLE` means not armed and nothing pending. `TRK_ARMED` means waiting for the count to reach zero. `TRK_PEND` means the completion interrupt is pending. The transitions are:

- arm while work remains: IDLE→ARMED
- arm with nothing left: IDLE→PEND
- last completion while armed: ARMED→PEND
- software clears the pending bit: ARMED→IDLE or PEND→IDLE

The pending bit and its enable bit sit in the supervisor interrupt registers. The block drives an interrupt request together with its cause code. Arbitration against the hart's other interrupts is left to the surrounding logic.

Top module: `tlbi_done_tracker`

## Requirements
- R1: After reset the outstanding count is zero. All read ports return 0, `irq_o` and `cause_o` are 0, and `issue_ready_o` is 1.
- R2: A status write with bit XLEN-3 set to 1 arms the completion check. The same write with that bit at 0 arms nothing. Bit XLEN-3 always reads back 0.
- R3: Status bit XLEN-2 reads 1 exactly while the outstanding count is nonzero. An accepted issue raises the count by one and a counted completion lowers it by one.
- R4: If the check is armed, the cycle in which the count reaches zero sets the pending bit (bit 13 of `ip_rdata_o`) at the same edge that clears the busy bit. If the busy bit falls without the check armed, pending stays 0.
- R5: Arming while nothing is outstanding sets the pending bit after the next clock edge.
- R6: The enable bit is bit 13, written through the enable port and read back on `ie_rdata_o`. `irq_o` is pending AND enable, so a cleared enable masks the interrupt.
- R7: While `irq_o` is 1, `cause_o` has bit XLEN-1 set and the value 12 in its low bits, with all other bits 0. While `irq_o` is 0, `cause_o` is 0.
- R8: A completion is counted only when `cmpl_src_i` equals the HART_ID parameter. A completion that arrives with a count of zero is ignored.
- R9: An accepted issue and a counted completion in the same cycle, with at least one invalidate outstanding, leave the count unchanged.
- R10: At a count of 2^CNT_W-1, `issue_ready_o` is 0 and `issue_valid_i` is not counted.
- R11: Writing 0 to bit 13 of the pending register clears the pending bit and also disarms an armed check. Writing 1 to it does not set pending. A status write that arms while pending is already set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Fence encoder sent one broadcast invalidate |
| issue_ready_o | output | 1 | Counter can accept another issue |
| cmpl_valid_i | input | 1 | Interconnect completion pulse |
| cmpl_src_i | input | ID_W | Hart that issued the completed invalidate |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | XLEN | Status write data |
| stat_rdata_o | output | XLEN | Status read view (busy flag; check bit reads 0) |
| ip_we_i | input | 1 | Interrupt-pending register write strobe |
| ip_wdata_i | input | XLEN | Interrupt-pending write data |
| ip_rdata_o | output | XLEN | Interrupt-pending read view (bit 13) |
| ie_we_i | input | 1 | Interrupt-enable register write strobe |
| ie_wdata_i | input | XLEN | Interrupt-enable write data |
| ie_rdata_o | output | XLEN | Interrupt-enable read view (bit 13) |
| irq_o | output | 1 | Completion interrupt request |
| cause_o | output | XLEN | Cause value while the request is raised |

## Verification
The bench targets these corner cases:

- **Last completion while armed.** A design that raised pending one cycle after busy fell would fail the same-edge check.
- **Arming with nothing outstanding.** A design that waited for a busy-flag edge would never interrupt.
- **Issue and completion in the same cycle.** An unbalanced update would end with busy dropping a completion early or late.
- **A full counter.** A missing back-pressure guard would wrap the count to zero.
- **Foreign or stray completions.** Counting them would clear busy early.
- **Clearing while armed.** A design that did not disarm would raise a spurious interrupt later.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_ARMED = 2'd1,
        TRK_PEND  = 2'd2
    } trk_state_e;

    localparam int unsigned IRQ_BIT    = 13;
    localparam int unsigned CAUSE_CODE = 12;

endpackage

// File: rtl/tlbi_outstanding_ctr.sv
module tlbi_outstanding_ctr #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned ID_W    = 4,
    parameter int unsigned HART_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid_i,
    input  logic            cmpl_valid_i,
    input  logic [ID_W-1:0] cmpl_src_i,
    output logic            issue_ready_o,
    output logic            busy_o,
    output logic            zero_nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [ID_W-1:0]  OWN_ID  = ID_W'(HART_ID);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             own_cmpl;
    logic             inc;
    logic             dec;

    assign own_cmpl      = cmpl_valid_i && (cmpl_src_i == OWN_ID);
    assign issue_ready_o = (cnt_q != CNT_MAX);
    assign inc           = issue_valid_i && issue_ready_o;
    assign dec           = own_cmpl && (cnt_q != '0);

    always_comb begin
        unique case ({inc, dec})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o     = (cnt_q != '0);
    assign zero_nxt_o = (cnt_d == '0);

    // R10: a full counter never wraps
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !own_cmpl) |=> (cnt_q == CNT_MAX));

    // R9: balanced issue and completion hold the count
    assert_balanced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_ready_o && own_cmpl && busy_o) |=> (cnt_q == $past(cnt_q)));

    // R8: a completion at zero leaves the count at zero unless an issue is accepted
    assert_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !issue_valid_i) |=> !busy_o);
endmodule

// File: rtl/tlbi_arm_fsm.sv
module tlbi_arm_fsm
    import tlbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req_i,
    input  logic clr_req_i,
    input  logic zero_nxt_i,
    input  logic busy_i,
    output logic pend_o
);
    trk_state_e state_q;
    trk_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (arm_req_i) state_d = zero_nxt_i ? TRK_PEND : TRK_ARMED;
            end
            TRK_ARMED: begin
                if (clr_req_i)       state_d = TRK_IDLE;
                else if (zero_nxt_i) state_d = TRK_PEND;
            end
            TRK_PEND: begin
                if (clr_req_i) state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == TRK_PEND);
    end

    // R4: pending never rises while invalidates are still outstanding
    assert_pend_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> !busy_i);

    // R11: a clear request drops pending at the next edge
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> !pend_o);
endmodule

// File: rtl/tlbi_csr_view.sv
module tlbi_csr_view
    import tlbi_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_we_i,
    input  logic [XLEN-1:0] stat_wdata_i,
    input  logic            ip_we_i,
    input  logic [XLEN-1:0] ip_wdata_i,
    input  logic            ie_we_i,
    input  logic [XLEN-1:0] ie_wdata_i,
    input  logic            busy_i,
    input  logic            pend_i,
    output logic            arm_req_o,
    output logic            clr_req_o,
    output logic [XLEN-1:0] stat_rdata_o,
    output logic [XLEN-1:0] ip_rdata_o,
    output logic [XLEN-1:0] ie_rdata_o,
    output logic            irq_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int unsigned     BUSY_BIT  = XLEN - 2;
    localparam int unsigned     ARM_BIT   = XLEN - 3;
    localparam logic [XLEN-1:0] CAUSE_VAL = {1'b1, (XLEN-1)'(CAUSE_CODE)};

    logic ie_q;
    logic wdata_unused;

    assign wdata_unused = ^{stat_wdata_i, ip_wdata_i, ie_wdata_i};

    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (ie_we_i) ie_q <= ie_wdata_i[IRQ_BIT];
    end

    assign arm_req_o = stat_we_i && stat_wdata_i[ARM_BIT];
    assign clr_req_o = ip_we_i && !ip_wdata_i[IRQ_BIT];

    always_comb begin
        stat_rdata_o           = '0;
        stat_rdata_o[BUSY_BIT] = busy_i;
        ip_rdata_o             = '0;
        ip_rdata_o[IRQ_BIT]    = pend_i;
        ie_rdata_o             = '0;
        ie_rdata_o[IRQ_BIT]    = ie_q;
        irq_o                  = pend_i && ie_q;
        cause_o                = irq_o ? CAUSE_VAL : '0;
    end

    // R6: the request implies both pending and enable views are set
    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ip_rdata_o[IRQ_BIT] && ie_rdata_o[IRQ_BIT]));

    // R2: the check control bit never reads back as 1
    assert_arm_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req_o |=> !stat_rdata_o[ARM_BIT]);
endmodule

// File: rtl/tlbi_done_tracker.sv
module tlbi_done_tracker #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned ID_W    = 4,
    parameter int unsigned HART_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid_i,
    output logic            issue_ready_o,
    input  logic            cmpl_valid_i,
    input  logic [ID_W-1:0] cmpl_src_i,
    input  logic            stat_we_i,
    input  logic [XLEN-1:0] stat_wdata_i,
    output logic [XLEN-1:0] stat_rdata_o,
    input  logic            ip_we_i,
    input  logic [XLEN-1:0] ip_wdata_i,
    output logic [XLEN-1:0] ip_rdata_o,
    input  logic            ie_we_i,
    input  logic [XLEN-1:0] ie_wdata_i,
    output logic [XLEN-1:0] ie_rdata_o,
    output logic            irq_o,
    output logic [XLEN-1:0] cause_o
);
    logic busy;
    logic zero_nxt;
    logic arm_req;
    logic clr_req;
    logic pend;

    tlbi_outstanding_ctr #(
        .CNT_W  (CNT_W),
        .ID_W   (ID_W),
        .HART_ID(HART_ID)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid_i(issue_valid_i),
        .cmpl_valid_i (cmpl_valid_i),
        .cmpl_src_i   (cmpl_src_i),
        .issue_ready_o(issue_ready_o),
        .busy_o       (busy),
        .zero_nxt_o   (zero_nxt)
    );

    tlbi_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req_i (arm_req),
        .clr_req_i (clr_req),
        .zero_nxt_i(zero_nxt),
        .busy_i    (busy),
        .pend_o    (pend)
    );

    tlbi_csr_view #(
        .XLEN(XLEN)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_we_i   (stat_we_i),
        .stat_wdata_i(stat_wdata_i),
        .ip_we_i     (ip_we_i),
        .ip_wdata_i  (ip_wdata_i),
        .ie_we_i     (ie_we_i),
        .ie_wdata_i  (ie_wdata_i),
        .busy_i      (busy),
        .pend_i      (pend),
        .arm_req_o   (arm_req),
        .clr_req_o   (clr_req),
        .stat_rdata_o(stat_rdata_o),
        .ip_rdata_o  (ip_rdata_o),
        .ie_rdata_o  (ie_rdata_o),
        .irq_o       (irq_o),
        .cause_o     (cause_o)
    );

    // R7: the cause code is present whenever the request is raised
    assert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cause_o[XLEN-1] && cause_o[3:0] == 4'd12));
endmodule

// File: tb/sim_tlbi_done_tracker.sv
module sim_tlbi_done_tracker;
    localparam int XLEN = 64;
    localparam int CNT_W = 4;
    localparam int ID_W = 4;
    localparam int BUSY = XLEN - 2;
    localparam int ARM = XLEN - 3;
    localparam logic [XLEN-1:0] CAUSE_EXP = 64'h8000_0000_0000_000C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic issue_ready;
    logic cmpl_valid = 1'b0;
    logic [ID_W-1:0] cmpl_src = '0;
    logic stat_we = 1'b0;
    logic [XLEN-1:0] stat_wdata = '0;
    logic [XLEN-1:0] stat_rdata;
    logic ip_we = 1'b0;
    logic [XLEN-1:0] ip_wdata = '0;
    logic [XLEN-1:0] ip_rdata;
    logic ie_we = 1'b0;
    logic [XLEN-1:0] ie_wdata = '0;
    logic [XLEN-1:0] ie_rdata;
    logic irq;
    logic [XLEN-1:0] cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlbi_done_tracker #(.XLEN(XLEN), .CNT_W(CNT_W), .ID_W(ID_W), .HART_ID(3)) u0 (
        .clk(clk), .rst_n(rst_n),
        .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
        .cmpl_valid_i(cmpl_valid), .cmpl_src_i(cmpl_src),
        .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .stat_rdata_o(stat_rdata),
        .ip_we_i(ip_we), .ip_wdata_i(ip_wdata), .ip_rdata_o(ip_rdata),
        .ie_we_i(ie_we), .ie_wdata_i(ie_wdata), .ie_rdata_o(ie_rdata),
        .irq_o(irq), .cause_o(cause)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all drives happen right after a falling edge; one call passes one rising edge
    task automatic step();
        @(negedge clk);
        issue_valid = 1'b0; cmpl_valid = 1'b0; stat_we = 1'b0; ip_we = 1'b0; ie_we = 1'b0;
    endtask

    task automatic issue(input int n);
        for (int i = 0; i < n; i++) begin issue_valid = 1'b1; step(); end
    endtask

    task automatic complete(input logic [ID_W-1:0] src);
        cmpl_valid = 1'b1; cmpl_src = src; step();
    endtask

    task automatic arm(input logic bitv);
        stat_we = 1'b1; stat_wdata = '0; stat_wdata[ARM] = bitv; step();
    endtask

    task automatic ip_write(input logic bitv);
        ip_we = 1'b1; ip_wdata = '0; ip_wdata[13] = bitv; step();
    endtask

    task automatic ie_write(input logic bitv);
        ie_we = 1'b1; ie_wdata = '0; ie_wdata[13] = bitv; step();
    endtask

    task automatic t_reset();
        chk("R1 status", stat_rdata, '0);
        chk("R1 pending", ip_rdata, '0);
        chk("R1 enable", ie_rdata, '0);
        chk("R1 irq", {63'd0, irq}, '0);
        chk("R1 cause", cause, '0);
        chk("R1 ready", {63'd0, issue_ready}, 64'd1);
    endtask

    task automatic t_armed_completion();
        issue(3);
        chk("R3 busy set", {63'd0, stat_rdata[BUSY]}, 64'd1);
        arm(1'b1);
        chk("R2 arm reads zero", {63'd0, stat_rdata[ARM]}, '0);
        complete(4'd3); complete(4'd3);
        chk("R4 no early pending", {63'd0, ip_rdata[13]}, '0);
        complete(4'd5);
        chk("R8 foreign ignored", {63'd0, stat_rdata[BUSY]}, 64'd1);
        complete(4'd3);
        chk("R4 busy clear", {63'd0, stat_rdata[BUSY]}, '0);
        chk("R4 pending same edge", {63'd0, ip_rdata[13]}, 64'd1);
        chk("R6 masked irq", {63'd0, irq}, '0);
        chk("R7 cause idle", cause, '0);
        ie_write(1'b1);
        chk("R6 enable readback", {63'd0, ie_rdata[13]}, 64'd1);
        chk("R6 irq raised", {63'd0, irq}, 64'd1);
        chk("R7 cause code", cause, CAUSE_EXP);
        ip_write(1'b1);
        chk("R11 write one keeps", {63'd0, ip_rdata[13]}, 64'd1);
        arm(1'b1);
        chk("R11 arm while pending", {63'd0, ip_rdata[13]}, 64'd1);
        ip_write(1'b0);
        chk("R11 cleared", {63'd0, ip_rdata[13]}, '0);
        chk("R11 irq dropped", {63'd0, irq}, '0);
    endtask

    task automatic t_arm_empty();
        arm(1'b1);
        chk("R5 pending next cycle", {63'd0, ip_rdata[13]}, 64'd1);
        ip_write(1'b0);
    endtask

    task automatic t_no_arm();
        ip_write(1'b1);
        chk("R11 write one no set", {63'd0, ip_rdata[13]}, '0);
        issue(1);
        arm(1'b0);
        complete(4'd3);
        chk("R2 write zero no arm", {63'd0, ip_rdata[13]}, '0);
        chk("R4 unarmed fall", {63'd0, stat_rdata[BUSY]}, '0);
        issue(1);
        arm(1'b1);
        ip_write(1'b0);
        complete(4'd3);
        chk("R11 disarmed", {63'd0, ip_rdata[13]}, '0);
    endtask

    task automatic t_simultaneous();
        issue(1);
        issue_valid = 1'b1; cmpl_valid = 1'b1; cmpl_src = 4'd3; step();
        chk("R9 still busy", {63'd0, stat_rdata[BUSY]}, 64'd1);
        complete(4'd3);
        chk("R9 single left", {63'd0, stat_rdata[BUSY]}, '0);
    endtask

    task automatic t_stray();
        complete(4'd3);
        issue(1);
        chk("R8 stray ignored busy", {63'd0, stat_rdata[BUSY]}, 64'd1);
        complete(4'd3);
        chk("R8 stray ignored clear", {63'd0, stat_rdata[BUSY]}, '0);
    endtask

    task automatic t_full();
        issue(15);
        chk("R10 not ready", {63'd0, issue_ready}, '0);
        issue(2);
        for (int i = 0; i < 14; i++) complete(4'd3);
        chk("R10 one left", {63'd0, stat_rdata[BUSY]}, 64'd1);
        chk("R10 ready again", {63'd0, issue_ready}, 64'd1);
        complete(4'd3);
        chk("R10 drained", {63'd0, stat_rdata[BUSY]}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_armed_completion();
        t_arm_empty();
        t_no_arm();
        t_simultaneous();
        t_stray();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule